// File: doc/BRIEF.md
# Compressed Final-State Engine for a 4-State Recursive Encoder

This block finds the state that a 4-state recursive convolutional encoder reaches after it consumes a run of N information bits, without stepping the trellis once per bit. The encoder state is two bits, {x1, x0}. One trellis step with input bit d moves the state from (x0, x1) to (x0 ^ x1 ^ d, x0). The transition matrix of this recursion returns to identity after three steps. The block therefore XOR-folds the incoming bits into three lanes, indexed by bit position modulo 3. It then replays only the three folded bits through the recursion, followed by (N mod 3) steps with a zero input.

A collection opens with a start pulse that loads the initial state. Bits then arrive serially, qualified by a valid strobe, and the final bit also carries a last marker. After the last bit the block runs at most five trellis steps. It raises a one-cycle done pulse and holds the final state until the next start. Typical use is to find where a long section of a heavily punctured trellis, one that carries no redundancy, ends up. The section is then processed in a handful of cycles instead of one cycle per bit.

Top module: `trellis_final_state`

## Requirements
- R1: While rst_ni is low and after its release, state_o reads 2'b00 and done_o reads 0.
- R2: A cycle with start_i high loads init_state_i, and state_o shows that value in the following cycle. Encoding: state_o[0] is x0 and state_o[1] is x1.
- R3: When done_o is high, state_o equals the result of applying the serial recursion (x0, x1) -> (x0 ^ x1 ^ d, x0) to the accepted bits in arrival order, starting from the loaded state.
- R4: Take the clock edge that accepts the bit marked last as edge 0. Then done_o is high for the cycle after edge 3 + (N mod 3), where N is the number of accepted bits in the collection.
- R5: done_o is high for exactly one cycle. state_o then holds the final state unchanged until the next start pulse.
- R6: Cycles with bit_valid_i low contribute nothing, whatever bit_i and bit_last_i carry, so gaps in the bit stream do not change the result.
- R7: Bits offered while no collection is open have no effect on state_o and raise no done_o. This covers the idle time before a start and after a result, and the time while a result is being computed.
- R8: A start pulse during a collection or during the final steps discards that job, and no done_o is raised for it. The result then reflects only the bits after the new start.
- R9: A bit offered in the same cycle as start_i is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new collection and loads init_state_i |
| init_state_i | input | 2 | Initial encoder state {x1, x0} |
| bit_i | input | 1 | Information bit |
| bit_valid_i | input | 1 | bit_i is offered this cycle |
| bit_last_i | input | 1 | The offered bit is the final one of the collection |
| state_o | output | 2 | Encoder state {x1, x0}; the final state while done_o is high and afterwards |
| done_o | output | 1 | One-cycle pulse when the final state is ready |

## Verification
The bench builds the block with its default parameters: four trellis states, which gives a fold length of three and at most five compressed steps. Run lengths go up to 200 bits, so every residue of N modulo 3 is reached many times, and each lane folds dozens of bits. This exercises all three step counts after the fold. Results are compared against a bit-serial recursion in the bench. Bits are also offered in gaps, before a start, during the final steps and in the start cycle, and jobs are aborted mid-run.

// File: rtl/trellis_fold_pkg.sv
package trellis_fold_pkg;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned STATE_W    = $clog2(NUM_STATES);
  localparam int unsigned FOLD_LEN   = NUM_STATES - 1;
  localparam int unsigned PHASE_W    = $clog2(FOLD_LEN);
  localparam int unsigned STAGE_W    = $clog2(2 * FOLD_LEN);

  typedef logic [STATE_W-1:0] state_t;

  // s[0] = x0, s[1] = x1 ; x0' = x0^x1^d, x1' = x0
  function automatic state_t trellis_step(state_t s, logic d);
    return {s[0], s[0] ^ s[1] ^ d};
  endfunction
endpackage

// File: rtl/trellis_fold_acc.sv
module trellis_fold_acc
  import trellis_fold_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                en_i,
  input  logic                bit_i,
  output logic [FOLD_LEN-1:0] agg_o,
  output logic [PHASE_W-1:0]  phase_o
);
  localparam logic [PHASE_W-1:0] PHASE_MAX = PHASE_W'(FOLD_LEN - 1);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (clear_i) phase_q <= '0;
    else if (en_i)    phase_q <= (phase_q == PHASE_MAX) ? '0 : phase_q + 1'b1;
  end

  for (genvar l = 0; l < FOLD_LEN; l++) begin : g_lane
    logic lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lane_q <= 1'b0;
      else if (clear_i)                              lane_q <= 1'b0;
      else if (en_i && phase_q == PHASE_W'(l))       lane_q <= lane_q ^ bit_i;
    end
    assign agg_o[l] = lane_q;
  end

  assign phase_o = phase_q;

  p_phase_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PHASE_MAX);
  p_phase_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(phase_q) && $stable(agg_o));
endmodule

// File: rtl/trellis_stage_run.sv
module trellis_stage_run
  import trellis_fold_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  state_t              load_state_i,
  input  logic                go_i,
  input  logic [FOLD_LEN-1:0] agg_i,
  input  logic [PHASE_W-1:0]  phi_i,
  output state_t              state_o,
  output logic                done_o,
  output logic                busy_o
);
  state_t             st_q;
  logic [STAGE_W-1:0] cnt_q;
  logic               run_q, done_q;
  logic [STAGE_W-1:0] last_stage;
  logic               stage_bit;

  assign last_stage = STAGE_W'(FOLD_LEN - 1) + STAGE_W'(phi_i);

  // folded lanes first, zero input for the remaining phi stages
  always_comb begin
    stage_bit = 1'b0;
    for (int l = 0; l < FOLD_LEN; l++)
      if (cnt_q == STAGE_W'(l)) stage_bit = agg_i[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        st_q  <= load_state_i;
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (go_i) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        st_q  <= trellis_step(st_q, stage_bit);
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == last_stage) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
  assign busy_o  = run_q;

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(run_q) && !run_q);
  p_stage_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= last_stage);
  p_hold_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load_i) |=> $stable(st_q));
  p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_q && !run_q);
endmodule

// File: rtl/trellis_final_state.sv
module trellis_final_state
  import trellis_fold_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [STATE_W-1:0] init_state_i,
  input  logic               bit_i,
  input  logic               bit_valid_i,
  input  logic               bit_last_i,
  output logic [STATE_W-1:0] state_o,
  output logic               done_o
);
  logic                collect_q;
  logic                accept, go;
  logic [FOLD_LEN-1:0] agg;
  logic [PHASE_W-1:0]  phase;
  logic                busy;

  assign accept = collect_q && bit_valid_i && !start_i;
  assign go     = accept && bit_last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      collect_q <= 1'b0;
    else if (start_i) collect_q <= 1'b1;
    else if (go)      collect_q <= 1'b0;
  end

  trellis_fold_acc u_fold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .en_i    (accept),
    .bit_i   (bit_i),
    .agg_o   (agg),
    .phase_o (phase)
  );

  // after the last bit the phase counter holds N mod FOLD_LEN
  trellis_stage_run u_run (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_i),
    .load_state_i (init_state_i),
    .go_i         (go),
    .agg_i        (agg),
    .phi_i        (phase),
    .state_o      (state_o),
    .done_o       (done_o),
    .busy_o       (busy)
  );

  p_mode_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(collect_q && busy));
  p_fold_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !start_i) |=> $stable(agg) && $stable(phase));
  p_start_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> phase == '0 && agg == '0);
endmodule

// File: tb/tb_trellis_final_state.sv
`timescale 1ns/100ps
module tb_trellis_final_state;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] init_state_i = '0;
  logic       bit_i = 1'b0, bit_valid_i = 1'b0, bit_last_i = 1'b0;
  logic [1:0] state_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  trellis_final_state dut (.*);

  // {init[1:0], len[3:0], bits[7:0] (bit i = i-th bit sent), expected[1:0]}
  localparam logic [15:0] VEC [5] = '{
    {2'b00, 4'd1, 8'b0000_0001, 2'b01},
    {2'b00, 4'd3, 8'b0000_0001, 2'b10},
    {2'b11, 4'd3, 8'b0000_0000, 2'b11},
    {2'b01, 4'd2, 8'b0000_0011, 2'b00},
    {2'b00, 4'd4, 8'b0000_1111, 2'b01}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_final(logic [1:0] s, int n, logic [199:0] b);
    for (int i = 0; i < n; i++) s = {s[0], s[0] ^ s[1] ^ b[i]};
    return s;
  endfunction

  // called at a negedge; returns at a negedge
  task automatic run_seq(input logic [1:0] init, input int n, input logic [199:0] bits,
                         input logic [1:0] exp, input bit gaps, input bit flood,
                         input bit start_bit);
    int  k;
    bit  saw_done;
    logic [1:0] held;
    start_i = 1'b1; init_state_i = init;
    bit_valid_i = start_bit; bit_i = 1'b1; bit_last_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0; bit_valid_i = 1'b0;
    chk(state_o == init, "R2", "loaded state", state_o, init);
    saw_done = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 0)) begin
        bit_valid_i = 1'b0; bit_i = 1'b1; bit_last_i = 1'b1;
        @(negedge clk_i);
        saw_done |= done_o;
      end
      bit_valid_i = 1'b1; bit_i = bits[i]; bit_last_i = (i == n - 1);
      @(negedge clk_i);
      saw_done |= done_o;
    end
    chk(!saw_done, "R8", "no done while collecting", saw_done, 0);
    // the last bit was taken at the posedge just passed (edge 0)
    bit_valid_i = flood; bit_i = 1'b1; bit_last_i = flood;
    k = 0;
    while (!done_o && k < 20) begin
      @(posedge clk_i); k++;
      @(negedge clk_i);
      if (flood) begin bit_i = ~bit_i; bit_last_i = k[0]; end
    end
    bit_valid_i = 1'b0; bit_last_i = 1'b0;
    chk(k == 3 + n % 3, "R4", "done latency", k, 3 + n % 3);
    chk(state_o == exp, "R3", "final state", state_o, exp);
    held = state_o;
    @(negedge clk_i);
    chk(!done_o && state_o == held, "R5", "one-cycle done, held state",
        {done_o, state_o}, {1'b0, held});
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [199:0] bits;
    logic [1:0]   init, held;
    int           n;

    // R1: reset
    repeat (3) @(negedge clk_i);
    chk(state_o == 2'b00 && !done_o, "R1", "state/done in reset", {done_o, state_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(state_o == 2'b00 && !done_o, "R1", "state/done after reset", {done_o, state_o}, 0);

    // directed table (R2..R5)
    for (int v = 0; v < 5; v++) begin
      bits = '0; bits[7:0] = VEC[v][9:2];
      run_seq(VEC[v][15:14], int'(VEC[v][13:10]), bits, VEC[v][1:0], 1'b0, 1'b0, 1'b0);
    end

    // R7: bits while idle before a start
    held = state_o;
    for (int i = 0; i < 4; i++) begin
      bit_valid_i = 1'b1; bit_i = 1'b1; bit_last_i = (i == 3);
      @(negedge clk_i);
    end
    bit_valid_i = 1'b0; bit_last_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(state_o == held && !done_o, "R7", "idle bits ignored", state_o, held);

    // R6: gaps with junk in bit/last
    bits = '0; bits[4:0] = 5'b10110;
    run_seq(2'b10, 5, bits, ref_final(2'b10, 5, bits), 1'b1, 1'b0, 1'b0);

    // R7: bits offered while the final steps run
    bits = '0; bits[7:0] = 8'b0110_1001;
    run_seq(2'b01, 8, bits, ref_final(2'b01, 8, bits), 1'b0, 1'b1, 1'b0);

    // R9: bit in the start cycle is dropped
    bits = '0; bits[5:0] = 6'b001101;
    run_seq(2'b11, 6, bits, ref_final(2'b11, 6, bits), 1'b0, 1'b0, 1'b1);

    // R8: restart during a collection
    start_i = 1'b1; init_state_i = 2'b11;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      bit_valid_i = 1'b1; bit_i = i[0]; bit_last_i = 1'b0;
      @(negedge clk_i);
    end
    bits = '0; bits[6:0] = 7'b1010011;
    run_seq(2'b00, 7, bits, ref_final(2'b00, 7, bits), 1'b0, 1'b0, 1'b0);

    // R8: restart right after the last bit (final steps aborted)
    start_i = 1'b1; init_state_i = 2'b10;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      bit_valid_i = 1'b1; bit_i = 1'b1; bit_last_i = (i == 3);
      @(negedge clk_i);
    end
    bit_valid_i = 1'b0; bit_last_i = 1'b0;
    bits = '0; bits[9:0] = 10'b11_0100_1110;
    run_seq(2'b01, 10, bits, ref_final(2'b01, 10, bits), 1'b0, 1'b0, 1'b0);

    // R3/R4: random runs against the serial recursion
    for (int t = 0; t < 40; t++) begin
      n = int'($urandom_range(1, 200));
      init = 2'($urandom_range(0, 3));
      for (int i = 0; i < 200; i++) bits[i] = 1'($urandom_range(0, 1));
      run_seq(init, n, bits, ref_final(init, n, bits), t[2], t[3], t[1]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule